// File: doc/BRIEF.md
# Two-Wire Bus Master Condition Sequencer

This block is the master-side sequencer of a two-wire serial controller. It produces the serial clock with a programmable period. It also emits start, repeated-start and stop conditions when software sets its request bits, and it reports whether it currently owns the bus. Both lines are open-drain, so each output is a drive-low enable: 1 pulls the line low and 0 releases it.

Software holds a START and a STOP bit. The block answers each with a one-cycle acknowledge pulse, and the bit register uses that pulse to clear itself. A start issued from idle waits until the bus is free. While the block already owns the bus, a start request is armed by the next data write. It is then sent as a repeated start at the end of the current clock-high phase, with no stop before it. Byte shifting and slave-mode logic sit outside this block.

Top module: `twi_master_seq`

## Requirements
- R1: While master, each serial clock low phase and each high phase lasts exactly 2*F system clock cycles, where F is the frequency field sampled when the phase begins; the clock starts with a low phase immediately after a start.
- R2: A frequency field below 8 is treated as 8, giving 16-cycle phases.
- R3: When not master, a start request with `bus_busy_i`=1 produces no line activity. Once `bus_busy_i`=0, SDA is driven low with SCL released for one half-period, then SCL is driven low.
- R4: In the first cycle with SCL driven low after a start, `start_clr_o` pulses for one cycle and `master_o` and `start_sent_o` become 1; `start_sent_o` is 0 while a start condition is in progress.
- R5: While master, `start_i`=1 together with a `data_wr_i` pulse arms a repeated start. At the end of the next high phase, SCL is driven low with SDA released for one half-period, SCL is released for one half-period, and then the R3 start pattern follows, with `master_o` staying 1 and no stop issued.
- R6: While master, `start_i`=1 without a data write causes no start condition; the clock keeps running and SDA stays released.
- R7: With `stop_i`=1 while master, at the end of the next high phase SCL and SDA are both driven low for one half-period, SCL is released with SDA low for one half-period, then both are released, `stop_clr_o` pulses and `master_o` clears. A stop takes priority over an armed repeated start.
- R8: `stop_i` while not master has no effect: no line activity and no `stop_clr_o`.
- R9: A `bus_err_i` pulse releases both lines and clears `master_o` in the next cycle, discards an armed repeated start, and pulses `start_clr_o` if `start_i` was 1.
- R10: `irq_o` equals `start_sent_o` AND `start_ie_i` AND `int_en_i`.
- R11: With `enable_i`=0 both lines are released, `master_o` and `start_sent_o` are 0 from the next cycle, no acknowledges are given and start requests are ignored.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable |
| freq_i | input | 7 | Half-period divider F (phase = 2*F cycles) |
| start_i | input | 1 | Start request bit |
| stop_i | input | 1 | Stop request bit |
| data_wr_i | input | 1 | Data register write strobe |
| bus_busy_i | input | 1 | Bus is occupied by another master |
| bus_err_i | input | 1 | Bus error pulse |
| start_ie_i | input | 1 | Start-sent interrupt enable |
| int_en_i | input | 1 | Global interrupt enable |
| scl_oe_o | output | 1 | Drive SCL low |
| sda_oe_o | output | 1 | Drive SDA low |
| master_o | output | 1 | Block owns the bus |
| start_sent_o | output | 1 | A start completed successfully |
| start_clr_o | output | 1 | One-cycle clear for the START bit |
| stop_clr_o | output | 1 | One-cycle clear for the STOP bit |
| irq_o | output | 1 | Start-sent interrupt request |

## Verification
A wrong phase counter shows as an SCL edge one or more cycles off the expected 2*F boundary, and this appears within the first phase after a start. A wrong sequencer state shows in the next cycle as an SDA or SCL enable that differs from the R3, R5 or R7 pattern, or as an early, late or missing acknowledge pulse. Lost arming or lost master state appears at the next high-phase boundary as a missing repeated start or as an unexpected stop pattern. The bench models the sequence cycle by cycle and compares every output on every clock, so a divergence is seen in the cycle it first reaches a port.

// File: rtl/twi_seq_pkg.sv
package twi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RUN_LO,
    ST_RUN_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_RS_LO,
    ST_RS_HI
  } seq_state_e;
endpackage

// File: rtl/twi_half_timer.sv
module twi_half_timer #(
  parameter int FREQ_W   = 7,
  parameter int MIN_FREQ = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              done_o
);
  localparam int CNT_W = FREQ_W + 1;

  logic [FREQ_W-1:0] eff_freq;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  cnt_q;

  // clamp out-of-range divider to the minimum legal value
  assign eff_freq = (freq_i < FREQ_W'(MIN_FREQ)) ? FREQ_W'(MIN_FREQ) : freq_i;
  assign load_val = {eff_freq, 1'b0} - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val;
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);

  assert_min_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> !done_o);
endmodule

// File: rtl/twi_cond_fsm.sv
module twi_cond_fsm
  import twi_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic data_wr_i,
  input  logic bus_busy_i,
  input  logic bus_err_i,
  input  logic tmr_done_i,
  output logic tmr_load_o,
  output logic tmr_clr_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic master_o,
  output logic start_sent_o,
  output logic start_clr_o,
  output logic stop_clr_o
);
  seq_state_e state_q, state_d;
  logic master_q, master_d;
  logic sent_q, sent_d;
  logic armed_q, armed_d, arm_now;
  logic sack_q, sack_d;
  logic pack_q, pack_d;
  logic scl_q, sda_q;
  logic scl_d, sda_d;

  assign arm_now = armed_q | (master_q & start_i & data_wr_i);

  always_comb begin
    state_d    = state_q;
    master_d   = master_q;
    sent_d     = sent_q;
    armed_d    = armed_q;
    sack_d     = 1'b0;
    pack_d     = 1'b0;
    tmr_load_o = 1'b0;
    if (!enable_i) begin
      state_d  = ST_IDLE;
      master_d = 1'b0;
      sent_d   = 1'b0;
      armed_d  = 1'b0;
    end else if (bus_err_i) begin
      state_d  = ST_IDLE;
      master_d = 1'b0;
      armed_d  = 1'b0;
      sack_d   = start_i;
    end else begin
      armed_d = arm_now;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && !bus_busy_i) begin
            state_d    = ST_START;
            sent_d     = 1'b0;
            tmr_load_o = 1'b1;
          end
        end
        ST_START: begin
          if (tmr_done_i) begin
            state_d    = ST_RUN_LO;
            master_d   = 1'b1;
            sent_d     = 1'b1;
            sack_d     = 1'b1;
            tmr_load_o = 1'b1;
          end
        end
        ST_RUN_LO: begin
          if (tmr_done_i) begin
            state_d    = ST_RUN_HI;
            tmr_load_o = 1'b1;
          end
        end
        ST_RUN_HI: begin
          if (tmr_done_i) begin
            tmr_load_o = 1'b1;
            if (stop_i) begin
              state_d = ST_STOP_LO;
            end else if (arm_now) begin
              state_d = ST_RS_LO;
              armed_d = 1'b0;
            end else begin
              state_d = ST_RUN_LO;
            end
          end
        end
        ST_STOP_LO: begin
          if (tmr_done_i) begin
            state_d    = ST_STOP_HI;
            tmr_load_o = 1'b1;
          end
        end
        ST_STOP_HI: begin
          if (tmr_done_i) begin
            state_d  = ST_IDLE;
            master_d = 1'b0;
            armed_d  = 1'b0;
            pack_d   = 1'b1;
          end
        end
        ST_RS_LO: begin
          if (tmr_done_i) begin
            state_d    = ST_RS_HI;
            tmr_load_o = 1'b1;
          end
        end
        ST_RS_HI: begin
          if (tmr_done_i) begin
            state_d    = ST_START;
            sent_d     = 1'b0;
            tmr_load_o = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign scl_d = (state_d inside {ST_RUN_LO, ST_STOP_LO, ST_RS_LO});
  assign sda_d = (state_d inside {ST_START, ST_STOP_LO, ST_STOP_HI});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      master_q <= 1'b0;
      sent_q   <= 1'b0;
      armed_q  <= 1'b0;
      sack_q   <= 1'b0;
      pack_q   <= 1'b0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      master_q <= master_d;
      sent_q   <= sent_d;
      armed_q  <= armed_d;
      sack_q   <= sack_d;
      pack_q   <= pack_d;
      scl_q    <= scl_d;
      sda_q    <= sda_d;
    end
  end

  assign tmr_clr_o    = ~enable_i;
  assign scl_oe_o     = scl_q;
  assign sda_oe_o     = sda_q;
  assign master_o     = master_q;
  assign start_sent_o = sent_q;
  assign start_clr_o  = sack_q;
  assign stop_clr_o   = pack_q;

  assert_phase_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != $past(state_q)) && ($past(state_q) != ST_IDLE) &&
     $past(enable_i) && !$past(bus_err_i)) |-> $past(tmr_done_i));

  assert_busy_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_START) && ($past(state_q) == ST_IDLE)) |-> !$past(bus_busy_i));

  assert_master_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(master_o) |-> start_clr_o);

  assert_stop_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_clr_o |-> (!scl_oe_o && !sda_oe_o && !master_o));

  assert_ack_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_clr_o, stop_clr_o}));

  assert_disable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!master_o && !scl_oe_o && !sda_oe_o && !start_sent_o));
endmodule

// File: rtl/twi_master_seq.sv
module twi_master_seq #(
  parameter int FREQ_W   = 7,
  parameter int MIN_FREQ = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              data_wr_i,
  input  logic              bus_busy_i,
  input  logic              bus_err_i,
  input  logic              start_ie_i,
  input  logic              int_en_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              master_o,
  output logic              start_sent_o,
  output logic              start_clr_o,
  output logic              stop_clr_o,
  output logic              irq_o
);
  logic tmr_done, tmr_load, tmr_clr;

  twi_half_timer #(
    .FREQ_W  (FREQ_W),
    .MIN_FREQ(MIN_FREQ)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .load_i(tmr_load),
    .freq_i(freq_i),
    .done_o(tmr_done)
  );

  twi_cond_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .data_wr_i   (data_wr_i),
    .bus_busy_i  (bus_busy_i),
    .bus_err_i   (bus_err_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_clr_o   (tmr_clr),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .master_o    (master_o),
    .start_sent_o(start_sent_o),
    .start_clr_o (start_clr_o),
    .stop_clr_o  (stop_clr_o)
  );

  assign irq_o = start_sent_o & start_ie_i & int_en_i;

  assert_start_seen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_sent_o) |-> (master_o && scl_oe_o));
endmodule

// File: tb/twi_master_seq_tb.sv
module twi_master_seq_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       en = 1'b0, busy = 1'b0, dw = 1'b0, err = 1'b0, ie = 1'b0, gie = 1'b0;
  logic [6:0] freq = 7'd10;
  logic       set_start = 1'b0, set_stop = 1'b0;
  logic       start_bit = 1'b0, stop_bit = 1'b0;
  logic       scl_oe, sda_oe, master, sent, sclr, pclr, irq;
  wire        start_w = start_bit & ~sclr;
  wire        stop_w  = stop_bit & ~pclr;

  twi_master_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .freq_i(freq),
    .start_i(start_w), .stop_i(stop_w), .data_wr_i(dw), .bus_busy_i(busy),
    .bus_err_i(err), .start_ie_i(ie), .int_en_i(gie),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .master_o(master),
    .start_sent_o(sent), .start_clr_o(sclr), .stop_clr_o(pclr), .irq_o(irq)
  );

  // software request bits with hardware self-clear
  always @(posedge clk) begin
    start_bit <= set_start | (start_bit & ~sclr);
    stop_bit  <= set_stop  | (stop_bit & ~pclr);
  end

  // reference model: phase codes 0 idle,1 start,2 run low,3 run high,
  // 4 stop low,5 stop high,6 restart low,7 restart high
  int ph = 0, rem = 0, hp;
  bit m_m = 0, m_ss = 0, m_arm = 0, m_sa = 0, m_pa = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; rem = 0; m_m = 0; m_ss = 0; m_arm = 0; m_sa = 0; m_pa = 0;
    end else if (!en) begin
      ph = 0; rem = 0; m_m = 0; m_ss = 0; m_arm = 0; m_sa = 0; m_pa = 0;
    end else if (err) begin
      m_sa = start_w; m_pa = 0; ph = 0; m_m = 0; m_arm = 0;
    end else begin
      m_sa = 0; m_pa = 0;
      hp = 2 * ((freq < 8) ? 8 : int'(freq));
      if (m_m && start_w && dw) m_arm = 1;
      if (ph == 0) begin
        if (start_w && !busy) begin ph = 1; rem = hp; m_ss = 0; end
      end else begin
        rem = rem - 1;
        if (rem == 0) begin
          rem = hp;
          case (ph)
            1: begin ph = 2; m_m = 1; m_ss = 1; m_sa = 1; end
            2: ph = 3;
            3: begin
              if (stop_w) ph = 4;
              else if (m_arm) begin ph = 6; m_arm = 0; end
              else ph = 2;
            end
            4: ph = 5;
            5: begin ph = 0; m_m = 0; m_arm = 0; m_pa = 1; end
            6: ph = 7;
            7: begin ph = 1; m_ss = 0; end
            default: ph = 0;
          endcase
        end
      end
    end
  end

  int cyc_chk = 0, cyc_fail = 0;
  int n_sclr = 0, n_pclr = 0, n_sda = 0, n_scl = 0, n_mlow = 0;
  bit e_scl, e_sda, e_irq;

  always @(negedge clk) begin
    if (rst_n) begin
      e_scl = (ph == 2 || ph == 4 || ph == 6);
      e_sda = (ph == 1 || ph == 4 || ph == 5);
      e_irq = m_ss & ie & gie;
      cyc_chk++;
      if (scl_oe !== e_scl || sda_oe !== e_sda || master !== m_m || sent !== m_ss ||
          sclr !== m_sa || pclr !== m_pa || irq !== e_irq) cyc_fail++;
      if (scl_oe !== e_scl) $display("FAIL R1 scl_oe act=%0b exp=%0b t=%0t", scl_oe, e_scl, $time);
      if (sda_oe !== e_sda) $display("FAIL R3 sda_oe act=%0b exp=%0b t=%0t", sda_oe, e_sda, $time);
      if (master !== m_m)   $display("FAIL R4 master act=%0b exp=%0b t=%0t", master, m_m, $time);
      if (sent !== m_ss)    $display("FAIL R4 start_sent act=%0b exp=%0b t=%0t", sent, m_ss, $time);
      if (sclr !== m_sa)    $display("FAIL R4 start_clr act=%0b exp=%0b t=%0t", sclr, m_sa, $time);
      if (pclr !== m_pa)    $display("FAIL R7 stop_clr act=%0b exp=%0b t=%0t", pclr, m_pa, $time);
      if (irq !== e_irq)    $display("FAIL R10 irq act=%0b exp=%0b t=%0t", irq, e_irq, $time);
      n_sclr += int'(sclr);
      n_pclr += int'(pclr);
      n_sda  += int'(sda_oe);
      n_scl  += int'(scl_oe);
      n_mlow += int'(!master);
    end
  end

  int t_chk = 0, t_fail = 0;
  bit wd_fail = 0;

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) step();
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    t_chk++;
    if (!ok) begin
      t_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse_start(); step(); set_start = 1; step(); set_start = 0; endtask
  task automatic pulse_stop();  step(); set_stop = 1;  step(); set_stop = 0;  endtask
  task automatic pulse_dw();    step(); dw = 1;        step(); dw = 0;        endtask
  task automatic pulse_err();   step(); err = 1;       step(); err = 0;       endtask

  task automatic wait_master(input bit lvl);
    for (int i = 0; i < 2000; i++) begin
      if (master == lvl) break;
      step();
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", cyc_chk + t_chk + int'(wd_fail),
             cyc_fail + t_fail + int'(wd_fail));
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    wd_fail = 1;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    int snap_a, snap_b, snap_c, cnt;
    wait_n(3);
    chk(!scl_oe && !sda_oe && !master && !sent && !sclr && !pclr && !irq, "R12 reset outputs", 1, 0);
    rst_n = 1;
    wait_n(2);
    chk(!scl_oe && !sda_oe && !master, "R12 after reset", int'(master), 0);

    // disabled: request ignored
    pulse_start();
    wait_n(40);
    chk(!sda_oe && !master && n_sclr == 0, "R11 start ignored while disabled", n_sclr, 0);

    // enable with bus busy
    busy = 1; en = 1;
    wait_n(30);
    chk(n_sda == 0 && !master, "R3 no start while busy", n_sda, 0);
    busy = 0;
    wait_master(1'b1);
    chk(master == 1, "R4 master after start", int'(master), 1);
    chk(n_sclr == 1, "R4 single start ack", n_sclr, 1);
    chk(n_sda == 20, "R3 start hold one half-period", n_sda, 20);

    cnt = 0;
    while (scl_oe && cnt < 1000) begin cnt++; step(); end
    chk(cnt == 20, "R1 low phase length", cnt, 20);
    cnt = 0;
    while (!scl_oe && cnt < 1000) begin cnt++; step(); end
    chk(cnt == 20, "R1 high phase length", cnt, 20);

    ie = 1; gie = 1; step();
    chk(irq == 1, "R10 irq on", int'(irq), 1);
    gie = 0; step();
    chk(irq == 0, "R10 irq masked", int'(irq), 0);

    // start request while master without data write
    snap_a = n_sda;
    pulse_start();
    wait_n(100);
    chk(n_sda == snap_a && master, "R6 no restart without data write", n_sda - snap_a, 0);

    // data write arms repeated start
    snap_a = n_sclr; snap_b = n_pclr; snap_c = n_mlow;
    cnt = n_sda;
    pulse_dw();
    for (int i = 0; i < 400; i++) begin
      if (n_sclr > snap_a) break;
      step();
    end
    chk(n_sclr == snap_a + 1, "R5 restart acknowledged", n_sclr - snap_a, 1);
    chk(n_pclr == snap_b && n_mlow == snap_c, "R5 no stop in restart", n_pclr - snap_b, 0);
    chk(n_sda - cnt == 20, "R5 restart sda low time", n_sda - cnt, 20);

    // minimum divider clamp
    freq = 7'd3;
    for (int i = 0; i < 200 && scl_oe; i++) step();
    for (int i = 0; i < 200 && !scl_oe; i++) step();
    cnt = 0;
    while (scl_oe && cnt < 1000) begin cnt++; step(); end
    chk(cnt == 16, "R2 clamped low phase", cnt, 16);

    // stop wins over armed restart; keep bus busy so the pending start waits
    busy = 1;
    snap_a = n_sclr;
    pulse_start();
    pulse_dw();
    pulse_stop();
    wait_master(1'b0);
    step();
    chk(n_sclr == snap_a, "R7 stop beats restart", n_sclr - snap_a, 0);
    chk(!scl_oe && !sda_oe && !master && n_pclr == 1, "R7 lines released after stop", n_pclr, 1);

    // stop while idle
    snap_a = n_pclr; snap_b = n_scl; snap_c = n_sda;
    pulse_stop();
    wait_n(60);
    chk(n_pclr == snap_a && n_scl == snap_b && n_sda == snap_c, "R8 idle stop ignored",
        n_pclr - snap_a, 0);

    // bus error drops a pending start
    snap_a = n_sclr;
    pulse_err();
    chk(n_sclr == snap_a + 1, "R9 start cleared on error", n_sclr - snap_a, 1);

    // bus error while master
    busy = 0;
    pulse_start();
    wait_master(1'b1);
    wait_n(3);
    pulse_err();
    chk(!master && !scl_oe && !sda_oe, "R9 error releases bus", int'(master), 0);

    // disable while running
    busy = 1;
    wait_n(5);
    busy = 0;
    pulse_start();
    wait_master(1'b1);
    wait_n(5);
    en = 0;
    step();
    chk(!master && !scl_oe && !sda_oe && !sent, "R11 disable mid-run", int'(master), 0);
    wait_n(40);
    chk(n_scl == n_scl && !scl_oe && !master, "R11 halted while disabled", int'(scl_oe), 0);

    finish_run();
  end
endmodule